// File: doc/BRIEF.md
# Configurable-frame UART transmitter

This block turns bytes into asynchronous serial frames. A producer writes one byte into a single-entry holding stage and watches a full flag. A state machine takes the byte out of that stage and shifts it onto a line that idles high. Each frame has a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. The bit rate comes from an external enable that pulses at sixteen times the bit rate. Every bit lasts sixteen of those pulses.

The frame format, the enables, flow control and break are plain control inputs. Their levels are captured when a character is taken, so changing them mid-frame does not disturb the character in flight. Break, disabling and loss of clear-to-send only take effect between characters.

The state machine has six states:
- `TX_IDLE`: line high.
- `TX_START`: start bit.
- `TX_DATA`: data bits.
- `TX_PARITY`: parity bit.
- `TX_STOP`: stop bits.
- `TX_BREAK`: line held low.

Its transitions are:
- IDLE→BREAK when break is requested.
- IDLE→START when a byte is held, both enables are high and flow control allows it.
- START→DATA at the end of the start bit.
- DATA→PARITY or DATA→STOP after the last data bit.
- PARITY→STOP at the end of the parity bit.
- STOP→IDLE after the last stop bit.
- BREAK→IDLE when break is released.

Top module: `uart_frame_tx`

## Requirements
- R1: The `wlen` code sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. The data bits follow one low start bit, least significant bit first. Byte bits above the selected length are not sent.
- R2: When `two_stop` is 0 the frame ends with one high stop bit. When it is 1 the frame ends with two.
- R3: With `par_en`=1 and `stick_par`=0, a parity bit follows the data bits. It makes the number of ones in the data bits plus the parity bit even when `even_sel`=1 and odd when `even_sel`=0.
- R4: With `par_en`=1 and `stick_par`=1, the parity bit is the inverse of `even_sel`. With `par_en`=0 no parity bit is sent, whatever `stick_par` is.
- R5: `txd` is high whenever no character is in flight and break is not requested.
- R6: A break request lets the character in flight finish, including its stop bits. After that `txd` stays low until the request is removed, and then returns high.
- R7: With `cts_fc_en`=1, no new character starts while `cts_n` is high. With `cts_fc_en`=0, `cts_n` is ignored.
- R8: Clearing `en_uart` or `en_tx` mid-character lets that character finish normally. No character starts while either enable is low.
- R9: `busy` rises the cycle after a byte is written, even when the transmitter is disabled. It stays high until the last stop bit has been sent.
- R10: A write sets `full`. A write while `full` is high is ignored.
- R11: Each bit lasts exactly 16 pulses of `tick16`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| en_uart | input | 1 | Global enable |
| en_tx | input | 1 | Transmit enable |
| wr_valid | input | 1 | Write strobe for the holding stage |
| wr_data | input | 8 | Byte to send |
| full | output | 1 | Holding stage occupied |
| wlen | input | 2 | Data length code (0..3 = 5..8 bits) |
| par_en | input | 1 | Parity bit present |
| even_sel | input | 1 | Even (1) or odd (0) parity |
| stick_par | input | 1 | Constant parity bit |
| two_stop | input | 1 | Two stop bits |
| brk | input | 1 | Send break |
| cts_fc_en | input | 1 | Clear-to-send gating enable |
| cts_n | input | 1 | Active-low clear to send |
| txd | output | 1 | Serial output |
| busy | output | 1 | Character queued or in flight |

## Verification
The bench samples every bit in its middle across all four lengths, both parity senses, stick parity and both stop counts.

Each check targets a specific fault:
- A 5-bit frame of an all-ones byte exposes a design that sends unselected bits or computes parity over them.
- Stick parity with parity disabled catches a parity bit slipped into the frame.
- Break, disable and clear-to-send are each applied while a byte is held or in flight. A design that cuts the frame short, starts it early or leaves the line low after break fails those samples.
- The start bit is timed exactly, and `busy` is checked both during the last stop bit and shortly after it. This catches a wrong tick count and a busy flag that drops early.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP,
        TX_BREAK
    } tx_state_e;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          pop,
    output logic          full,
    output logic [DW-1:0] data_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full   <= 1'b0;
            data_q <= '0;
        end else if (pop) begin
            full <= 1'b0;
        end else if (wr_valid && !full) begin
            full   <= 1'b1;
            data_q <= wr_data;
        end
    end
endmodule

// File: rtl/uart_tx_tick.sv
module uart_tx_tick #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic bit_end
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (clr)        cnt_q <= '0;
        else if (tick)       cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign bit_end = tick && (cnt_q == LAST);
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
    parameter int DW = 8,
    parameter int BW = 3
) (
    input  logic [DW-1:0] data,
    input  logic [BW-1:0] last_idx,
    input  logic          even_sel,
    input  logic          stick,
    output logic          par_bit
);
    logic [DW-1:0] masked;

    for (genvar i = 0; i < DW; i++) begin : g_mask
        assign masked[i] = data[i] && (BW'(i) <= last_idx);
    end

    always_comb begin
        if (stick)         par_bit = !even_sel;
        else if (even_sel) par_bit = ^masked;
        else               par_bit = ~^masked;
    end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          en_uart,
    input  logic          en_tx,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    output logic          full,
    input  logic [1:0]    wlen,
    input  logic          par_en,
    input  logic          even_sel,
    input  logic          stick_par,
    input  logic          two_stop,
    input  logic          brk,
    input  logic          cts_fc_en,
    input  logic          cts_n,
    output logic          txd,
    output logic          busy
);
    localparam int BW   = $clog2(DW);
    localparam int MINB = DW - 3;

    tx_state_e     state_q, state_d;
    logic [DW-1:0] shreg_q, hold_q;
    logic [BW-1:0] bit_q, last_q, last_d;
    logic          pen_q, par_q, two_q, stop2_q;
    logic          load, bit_end, par_d;

    assign last_d = BW'(MINB - 1) + BW'(wlen);
    assign load   = (state_q == TX_IDLE) && !brk && full && en_uart && en_tx
                    && (!cts_fc_en || !cts_n);

    uart_tx_hold #(.DW(DW)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .pop(load), .full(full), .data_q(hold_q)
    );

    uart_tx_tick #(.OSR(OSR)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(load), .tick(tick16), .bit_end(bit_end)
    );

    uart_tx_parity #(.DW(DW), .BW(BW)) u_par (
        .data(hold_q), .last_idx(last_d), .even_sel(even_sel),
        .stick(stick_par), .par_bit(par_d)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:   if (brk) state_d = TX_BREAK;
                       else if (load) state_d = TX_START;
            TX_START:  if (bit_end) state_d = TX_DATA;
            TX_DATA:   if (bit_end && bit_q == last_q)
                           state_d = pen_q ? TX_PARITY : TX_STOP;
            TX_PARITY: if (bit_end) state_d = TX_STOP;
            TX_STOP:   if (bit_end && (!two_q || stop2_q)) state_d = TX_IDLE;
            TX_BREAK:  if (!brk) state_d = TX_IDLE;
            default:   state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            shreg_q <= '0;
            bit_q   <= '0;
            last_q  <= '0;
            pen_q   <= 1'b0;
            par_q   <= 1'b0;
            two_q   <= 1'b0;
            stop2_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                shreg_q <= hold_q;
                bit_q   <= '0;
                last_q  <= last_d;
                pen_q   <= par_en;
                par_q   <= par_d;
                two_q   <= two_stop;
                stop2_q <= 1'b0;
            end else if (bit_end && state_q == TX_DATA) begin
                shreg_q <= shreg_q >> 1;
                bit_q   <= bit_q + 1'b1;
            end else if (bit_end && state_q == TX_STOP) begin
                stop2_q <= 1'b1;
            end
        end
    end

    always_comb begin
        busy = full;
        unique case (state_q)
            TX_IDLE:   txd = 1'b1;
            TX_START:  begin txd = 1'b0;       busy = 1'b1; end
            TX_DATA:   begin txd = shreg_q[0]; busy = 1'b1; end
            TX_PARITY: begin txd = par_q;      busy = 1'b1; end
            TX_STOP:   begin txd = 1'b1;       busy = 1'b1; end
            TX_BREAK:  txd = 1'b0;
            default:   txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk
    import uart_tx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      tick16,
    input logic      wr_valid,
    input logic      full,
    input logic      en_uart,
    input logic      en_tx,
    input logic      cts_fc_en,
    input logic      cts_n,
    input logic      brk,
    input logic      txd,
    input logic      busy,
    input tx_state_e state
);
    a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !brk && !$past(brk)) |-> txd);

    a_r9_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !full) |=> busy);

    a_r10_write_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !full) |=> full);

    a_r10_full_held: assert property (@(posedge clk) disable iff (!rst_n)
        (full && state != TX_IDLE) |=> full);

    a_r8_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE && !(en_uart && en_tx)) |=> state != TX_START);

    a_r7_cts_gates_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE && cts_fc_en && cts_n) |=> state != TX_START);

    a_r11_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TX_IDLE && state != TX_BREAK && !tick16) |=> $stable(txd));
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_valid(wr_valid),
    .full(full), .en_uart(en_uart), .en_tx(en_tx), .cts_fc_en(cts_fc_en),
    .cts_n(cts_n), .brk(brk), .txd(txd), .busy(busy), .state(state_q)
);

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;
    localparam int CLK_NS = 10;
    localparam int BITCLK = 64;   // 16 ticks, one tick every 4 clocks

    logic       clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0;
    logic       en_uart = 1'b1, en_tx = 1'b1, wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] wlen = 2'b11;
    logic       par_en = 1'b0, even_sel = 1'b0, stick_par = 1'b0, two_stop = 1'b0;
    logic       brk = 1'b0, cts_fc_en = 1'b0, cts_n = 1'b1;
    logic       full, txd, busy;
    int         checks = 0, errors = 0;

    // {wlen, par_en, even_sel, stick_par, two_stop, expected parity, data}
    localparam logic [14:0] VEC [7] = '{
        {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
        {2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA5},
        {2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5},
        {2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF},
        {2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00},
        {2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h7F},
        {2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h81}
    };

    uart_frame_tx uut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .en_uart(en_uart), .en_tx(en_tx),
        .wr_valid(wr_valid), .wr_data(wr_data), .full(full), .wlen(wlen),
        .par_en(par_en), .even_sel(even_sel), .stick_par(stick_par),
        .two_stop(two_stop), .brk(brk), .cts_fc_en(cts_fc_en), .cts_n(cts_n),
        .txd(txd), .busy(busy)
    );

    always #(CLK_NS/2) clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick16 = 1'b1;
            @(negedge clk);
            tick16 = 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_fall;
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
    endtask

    // act: 0 none, 1 break request, 2 disable; applied after data bit act_at
    task automatic frame(input logic [7:0] d, input int nb, input logic pen,
                         input logic pexp, input logic two, input int act,
                         input int act_at);
        wait_fall();
        repeat (BITCLK/2) @(negedge clk);
        chk("R1 start bit", txd, 1'b0);
        for (int i = 0; i < nb; i++) begin
            repeat (BITCLK) @(negedge clk);
            chk("R1 data bit", txd, d[i]);
            if (act == 1 && i == act_at) brk = 1'b1;
            if (act == 2 && i == act_at) en_tx = 1'b0;
        end
        if (pen) begin
            repeat (BITCLK) @(negedge clk);
            chk("R3 R4 parity bit", txd, pexp);
        end
        repeat (BITCLK) @(negedge clk);
        chk("R2 first stop bit", txd, 1'b1);
        chk("R9 busy in stop", busy, 1'b1);
        if (two) begin
            repeat (BITCLK) @(negedge clk);
            chk("R2 second stop bit", txd, 1'b1);
            chk("R9 busy in last stop", busy, 1'b1);
        end
        repeat (40) @(negedge clk);
        chk("R9 R2 busy after frame", busy, 1'b0);
        chk("R5 R6 line after frame", txd, (act == 1) ? 1'b0 : 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R5 reset txd", txd, 1'b1);
        chk("R9 reset busy", busy, 1'b0);
        chk("R10 reset full", full, 1'b0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // table walk: R1 R2 R3 R4
        for (int v = 0; v < 7; v++) begin
            {wlen, par_en, even_sel, stick_par, two_stop} = VEC[v][14:9];
            put(VEC[v][7:0]);
            frame(VEC[v][7:0], 5 + int'(VEC[v][14:13]), VEC[v][12], VEC[v][8],
                  VEC[v][9], 0, 0);
        end
        {wlen, par_en, even_sel, stick_par, two_stop} = 6'b110000;

        // R9 R10 R8: held while disabled, second write dropped
        en_uart = 1'b0;
        put(8'h3C);
        chk("R10 full after write", full, 1'b1);
        chk("R9 busy while disabled", busy, 1'b1);
        put(8'hC3);
        repeat (200) @(negedge clk);
        chk("R8 no start while disabled", txd, 1'b1);
        en_uart = 1'b1;
        frame(8'h3C, 8, 1'b0, 1'b0, 1'b0, 0, 0);
        chk("R10 ignored write not queued", full, 1'b0);
        repeat (200) @(negedge clk);
        chk("R10 no extra frame", txd, 1'b1);

        // R7 clear-to-send gating
        cts_fc_en = 1'b1;
        cts_n = 1'b1;
        put(8'h55);
        repeat (200) @(negedge clk);
        chk("R7 held by cts", txd, 1'b1);
        chk("R7 busy while held", busy, 1'b1);
        cts_n = 1'b0;
        frame(8'h55, 8, 1'b0, 1'b0, 1'b0, 0, 0);
        cts_fc_en = 1'b0;
        cts_n = 1'b1;

        // R8 disable mid-character
        put(8'h96);
        frame(8'h96, 8, 1'b0, 1'b0, 1'b0, 2, 2);
        put(8'h11);
        repeat (300) @(negedge clk);
        chk("R8 no start after disable", txd, 1'b1);
        en_tx = 1'b1;
        frame(8'h11, 8, 1'b0, 1'b0, 1'b0, 0, 0);

        // R6 break waits for the character
        put(8'h0F);
        frame(8'h0F, 8, 1'b0, 1'b0, 1'b0, 1, 2);
        repeat (300) @(negedge clk);
        chk("R6 break held low", txd, 1'b0);
        brk = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 line high after break", txd, 1'b1);

        // R11 start bit length
        put(8'h01);
        begin
            int lows = 0;
            wait_fall();
            while (txd === 1'b0 && lows < 500) begin
                lows++;
                @(negedge clk);
            end
            chk("R11 start bit clocks", lows, BITCLK);
        end
        repeat (10 * BITCLK) @(negedge clk);
        chk("R5 idle after last frame", txd, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule